// File: doc/BRIEF.md
# Pattern-Driven Memory Access Sequencer

This block plays back per-cycle control patterns kept in a small pattern store, one stored word per clock. Each word holds the levels of the external memory control lines for that step, a flag that returns one transfer acknowledge to the requester, and a flag that closes the routine. Every request kind has a fixed entry point in the store: single and burst reads, single and burst writes, refresh, and the exception routine. The sequencer jumps to that entry point and steps forward until it reaches the closing word.

Before any traffic, the host loads the pattern store through a write port. The port is active only while the sequencer is idle. A read or write request gives a word address, a length in words and a target bank. The block uses burst routines (eight acknowledges each) only when the start is 8-word aligned, the length is a nonzero multiple of eight and the bank allows bursts. Any other transfer is split into back-to-back single-beat runs with one acknowledge each. The sequencer counts acknowledges in each run and flags any run that closes with the wrong count.

Top module: `mem_pattern_seq`

## Requirements
- R1: While reset is asserted and whenever the block is idle, `busy`, `ctrl_out`, `ta`, `beat_start`, `done`, `ack_err` and `run_addr` are all zero.
- R2: A pattern word is CTRL_W+2 bits wide. Bits [CTRL_W-1:0] are the control levels, bit CTRL_W is the acknowledge flag and bit CTRL_W+1 is the closing flag. While busy, `ctrl_out` shows the control bits of the current word and `ta` shows its acknowledge bit.
- R3: Request kind encoding: 0 read, 1 write, 2 refresh, 3 exception. Runs start at word 0x00 (single read), 0x08 (burst read), 0x18 (single write), 0x20 (burst write), 0x30 (refresh) or 0x3C (exception).
- R4: An accepted request shows its first word in the cycle after the accepting clock edge. Each later cycle shows the next word address (modulo the store depth), and `busy` stays high until the last run closes.
- R5: When a word with the closing flag ends the final run, `done` pulses during that word and the block is idle in the next cycle.
- R6: A read or write whose address has bits [2:0] equal to zero, whose length is a nonzero multiple of 8 and whose bank is not burst-inhibited runs as length/8 burst runs. `run_addr` starts at the request address and advances by 8 per run.
- R7: Any other read or write runs as one single-beat run per word (a length of 0 counts as 1), with `run_addr` advancing by 1. A run that is not the last is followed directly by the next run's first word, and `beat_start` is high on the first word of every run.
- R8: `burst_inhibit[b]` high makes every read or write to bank b use single-beat runs, even when the request would otherwise qualify for bursts.
- R9: On the closing word of a read or write run, `ack_err` pulses if the run's acknowledge count, including that word, differs from 1 (single) or 8 (burst). Refresh and exception runs never raise `ack_err`.
- R10: Pattern store writes are ignored while `busy` is high.
- R11: `req_ready` equals not `busy`. A request presented while busy is ignored.
- R12: A refresh or exception request runs its routine exactly once, with `run_addr` equal to the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_we | input | 1 | Pattern store write strobe |
| ram_waddr | input | PC_W | Pattern store write address |
| ram_wdata | input | CTRL_W+2 | Pattern word to store |
| burst_inhibit | input | NUM_BANKS | Per-bank burst disable |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | Request kind (R3 encoding) |
| req_addr | input | WADDR_W | Start word address |
| req_len | input | LEN_W | Length in words |
| req_bank | input | BANK_W | Target bank |
| busy | output | 1 | A routine is running |
| ctrl_out | output | CTRL_W | Control levels of the current word |
| ta | output | 1 | Transfer acknowledge |
| beat_start | output | 1 | First word of a run (transfer start) |
| run_addr | output | WADDR_W | Word address of the current run |
| done | output | 1 | Final word of the request |
| ack_err | output | 1 | Run closed with a wrong acknowledge count |

## Verification
The hardest state to reach from the ports is a store write or a fresh request that arrives in the middle of a run. The bench reaches it by starting a refresh and then pulsing `ram_we` and `req_valid` while the routine is still stepping. It then runs a single read over the word it tried to overwrite, so the original contents must show on `ctrl_out`. The bench also produces wrong acknowledge counts by reloading a single-write routine with two acknowledges and a burst routine with seven, then runs a two-burst request so that each run reports its own error.

// File: rtl/mps_pkg.sv
package mps_pkg;

   typedef enum logic [1:0] {
      KIND_READ    = 2'd0,
      KIND_WRITE   = 2'd1,
      KIND_REFRESH = 2'd2,
      KIND_EXCEPT  = 2'd3
   } req_kind_e;

   localparam int ENTRY_RD_ONE   = 'h00;
   localparam int ENTRY_RD_BURST = 'h08;
   localparam int ENTRY_WR_ONE   = 'h18;
   localparam int ENTRY_WR_BURST = 'h20;
   localparam int ENTRY_REFRESH  = 'h30;
   localparam int ENTRY_EXCEPT   = 'h3C;

   localparam int BURST_ACKS  = 8;
   localparam int SINGLE_ACKS = 1;
   localparam int MIN_DEPTH   = 64;

   function automatic int entry_of(req_kind_e kind, logic use_burst);
      case (kind)
         KIND_READ:    return use_burst ? ENTRY_RD_BURST : ENTRY_RD_ONE;
         KIND_WRITE:   return use_burst ? ENTRY_WR_BURST : ENTRY_WR_ONE;
         KIND_REFRESH: return ENTRY_REFRESH;
         default:      return ENTRY_EXCEPT;
      endcase
   endfunction

endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
   parameter int DEPTH          = 64,
   parameter int WORD_W         = 10,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] cells [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (wr_en) begin
               cells[wr_addr] <= wr_data;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (wr_en) cells[wr_addr] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/mps_splitter.sv
module mps_splitter
   import mps_pkg::*;
#(
   parameter int LEN_W     = 8,
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int PC_W      = 6,
   parameter int WADDR_W   = 16,
   parameter int CNT_W     = 7
) (
   input  logic [1:0]           kind,
   input  logic [2:0]           addr_lo,
   input  logic [LEN_W-1:0]     len,
   input  logic [BANK_W-1:0]    bank,
   input  logic [NUM_BANKS-1:0] burst_inhibit,
   output logic [PC_W-1:0]      plan_entry,
   output logic [LEN_W-1:0]     plan_runs,
   output logic [WADDR_W-1:0]   plan_step,
   output logic [CNT_W-1:0]     plan_expect,
   output logic                 plan_check
);

   req_kind_e k;
   logic      is_rw;
   logic      bank_inh;
   logic      use_burst;

   assign k     = req_kind_e'(kind);
   assign is_rw = (k == KIND_READ) || (k == KIND_WRITE);

   always_comb begin
      bank_inh = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank == BANK_W'(b)) bank_inh = burst_inhibit[b];
      end
   end

   assign use_burst = is_rw && (addr_lo == 3'd0) && (len[2:0] == 3'd0)
                      && (len != '0) && !bank_inh;

   assign plan_entry = PC_W'(entry_of(k, use_burst));

   always_comb begin
      if (use_burst)                plan_runs = len >> 3;
      else if (is_rw && len != '0)  plan_runs = len;
      else                          plan_runs = LEN_W'(1);
   end

   assign plan_step   = use_burst ? WADDR_W'(BURST_ACKS) : WADDR_W'(1);
   assign plan_expect = use_burst ? CNT_W'(BURST_ACKS) : CNT_W'(SINGLE_ACKS);
   assign plan_check  = is_rw;

endmodule

// File: rtl/mps_step_engine.sv
module mps_step_engine #(
   parameter int CTRL_W  = 8,
   parameter int PC_W    = 6,
   parameter int LEN_W   = 8,
   parameter int WADDR_W = 16,
   parameter int CNT_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [WADDR_W-1:0] req_addr,
   input  logic [PC_W-1:0]    plan_entry,
   input  logic [LEN_W-1:0]   plan_runs,
   input  logic [WADDR_W-1:0] plan_step,
   input  logic [CNT_W-1:0]   plan_expect,
   input  logic               plan_check,
   input  logic [CTRL_W-1:0]  word_ctrl,
   input  logic               word_ack,
   input  logic               word_last,
   output logic [PC_W-1:0]    pc,
   output logic               busy,
   output logic [CTRL_W-1:0]  ctrl_out,
   output logic               ta,
   output logic               beat_start,
   output logic [WADDR_W-1:0] run_addr,
   output logic               done,
   output logic               ack_err
);

   logic               busy_q;
   logic [PC_W-1:0]    pc_q;
   logic [PC_W-1:0]    entry_q;
   logic               first_q;
   logic [CNT_W-1:0]   acks_q;
   logic [LEN_W-1:0]   runs_left_q;
   logic [WADDR_W-1:0] addr_q;
   logic [WADDR_W-1:0] step_q;
   logic [CNT_W-1:0]   expect_q;
   logic               check_q;
   logic               final_run;
   logic [CNT_W-1:0]   acks_total;

   assign final_run  = (runs_left_q == LEN_W'(1));
   assign acks_total = acks_q + CNT_W'(word_ack);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         pc_q        <= '0;
         entry_q     <= '0;
         first_q     <= 1'b0;
         acks_q      <= '0;
         runs_left_q <= '0;
         addr_q      <= '0;
         step_q      <= '0;
         expect_q    <= '0;
         check_q     <= 1'b0;
      end else if (!busy_q) begin
         if (accept) begin
            busy_q      <= 1'b1;
            pc_q        <= plan_entry;
            entry_q     <= plan_entry;
            first_q     <= 1'b1;
            acks_q      <= '0;
            runs_left_q <= plan_runs;
            addr_q      <= req_addr;
            step_q      <= plan_step;
            expect_q    <= plan_expect;
            check_q     <= plan_check;
         end
      end else if (word_last) begin
         if (final_run) begin
            busy_q <= 1'b0;
         end else begin
            runs_left_q <= runs_left_q - LEN_W'(1);
            pc_q        <= entry_q;
            first_q     <= 1'b1;
            acks_q      <= '0;
            addr_q      <= addr_q + step_q;
         end
      end else begin
         pc_q    <= pc_q + PC_W'(1);
         first_q <= 1'b0;
         if (acks_q != '1) acks_q <= acks_total;
      end
   end

   assign pc         = pc_q;
   assign busy       = busy_q;
   assign ctrl_out   = busy_q ? word_ctrl : '0;
   assign ta         = busy_q & word_ack;
   assign beat_start = busy_q & first_q;
   assign run_addr   = busy_q ? addr_q : '0;
   assign done       = busy_q & word_last & final_run;
   assign ack_err    = busy_q & word_last & check_q & (acks_total != expect_q);

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq #(
   parameter int CTRL_W         = 8,
   parameter int PAT_DEPTH      = 64,
   parameter int WADDR_W        = 16,
   parameter int LEN_W          = 8,
   parameter int NUM_BANKS      = 4,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int PC_W          = $clog2(PAT_DEPTH),
   localparam int WORD_W        = CTRL_W + 2,
   localparam int CNT_W         = PC_W + 1,
   localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ram_we,
   input  logic [PC_W-1:0]      ram_waddr,
   input  logic [WORD_W-1:0]    ram_wdata,
   input  logic [NUM_BANKS-1:0] burst_inhibit,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [1:0]           req_kind,
   input  logic [WADDR_W-1:0]   req_addr,
   input  logic [LEN_W-1:0]     req_len,
   input  logic [BANK_W-1:0]    req_bank,
   output logic                 busy,
   output logic [CTRL_W-1:0]    ctrl_out,
   output logic                 ta,
   output logic                 beat_start,
   output logic [WADDR_W-1:0]   run_addr,
   output logic                 done,
   output logic                 ack_err
);

   generate
      if (PAT_DEPTH < mps_pkg::MIN_DEPTH || (PAT_DEPTH & (PAT_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("PAT_DEPTH must be a power of two of at least 64");
      end
      if (LEN_W < 4) begin : g_bad_len
         $error("LEN_W must be at least 4");
      end
      if (WADDR_W < 4) begin : g_bad_addr
         $error("WADDR_W must be at least 4");
      end
      if (CTRL_W < 1) begin : g_bad_ctrl
         $error("CTRL_W must be at least 1");
      end
   endgenerate

   logic [PC_W-1:0]    pc;
   logic [WORD_W-1:0]  cur_word;
   logic [PC_W-1:0]    plan_entry;
   logic [LEN_W-1:0]   plan_runs;
   logic [WADDR_W-1:0] plan_step;
   logic [CNT_W-1:0]   plan_expect;
   logic               plan_check;

   mps_pattern_ram #(
      .DEPTH          (PAT_DEPTH),
      .WORD_W         (WORD_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ram_we & ~busy),
      .wr_addr (ram_waddr),
      .wr_data (ram_wdata),
      .rd_addr (pc),
      .rd_data (cur_word)
   );

   mps_splitter #(
      .LEN_W     (LEN_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .PC_W      (PC_W),
      .WADDR_W   (WADDR_W),
      .CNT_W     (CNT_W)
   ) u_split (
      .kind          (req_kind),
      .addr_lo       (req_addr[2:0]),
      .len           (req_len),
      .bank          (req_bank),
      .burst_inhibit (burst_inhibit),
      .plan_entry    (plan_entry),
      .plan_runs     (plan_runs),
      .plan_step     (plan_step),
      .plan_expect   (plan_expect),
      .plan_check    (plan_check)
   );

   mps_step_engine #(
      .CTRL_W  (CTRL_W),
      .PC_W    (PC_W),
      .LEN_W   (LEN_W),
      .WADDR_W (WADDR_W),
      .CNT_W   (CNT_W)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (req_valid),
      .req_addr    (req_addr),
      .plan_entry  (plan_entry),
      .plan_runs   (plan_runs),
      .plan_step   (plan_step),
      .plan_expect (plan_expect),
      .plan_check  (plan_check),
      .word_ctrl   (cur_word[CTRL_W-1:0]),
      .word_ack    (cur_word[CTRL_W]),
      .word_last   (cur_word[CTRL_W+1]),
      .pc          (pc),
      .busy        (busy),
      .ctrl_out    (ctrl_out),
      .ta          (ta),
      .beat_start  (beat_start),
      .run_addr    (run_addr),
      .done        (done),
      .ack_err     (ack_err)
   );

   assign req_ready = ~busy;

endmodule

// File: rtl/mps_seq_checker.sv
module mps_seq_checker #(
   parameter int CTRL_W  = 8,
   parameter int WADDR_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               busy,
   input logic [CTRL_W-1:0]  ctrl_out,
   input logic               ta,
   input logic               beat_start,
   input logic [WADDR_W-1:0] run_addr,
   input logic               done,
   input logic               ack_err
);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctrl_out == '0 && !ta && !beat_start && !done && !ack_err && run_addr == '0));

   a_r11_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (busy && beat_start));

   a_r11_no_unasked_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   a_r9_err_at_run_end: assert property (@(posedge clk) disable iff (!rst_n)
      ack_err |=> (!busy || beat_start));

endmodule

bind mem_pattern_seq mps_seq_checker #(
   .CTRL_W  (CTRL_W),
   .WADDR_W (WADDR_W)
) u_seq_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .busy       (busy),
   .ctrl_out   (ctrl_out),
   .ta         (ta),
   .beat_start (beat_start),
   .run_addr   (run_addr),
   .done       (done),
   .ack_err    (ack_err)
);

// File: tb/mem_pattern_seq_bench.sv
module mem_pattern_seq_bench;

   localparam int CTRL_W = 8;
   localparam int WORD_W = CTRL_W + 2;
   localparam int DEPTH  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ram_we = 1'b0;
   logic [5:0]  ram_waddr = '0;
   logic [9:0]  ram_wdata = '0;
   logic [3:0]  burst_inhibit = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_len = '0;
   logic [1:0]  req_bank = '0;
   logic        busy;
   logic [7:0]  ctrl_out;
   logic        ta;
   logic        beat_start;
   logic [15:0] run_addr;
   logic        done;
   logic        ack_err;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   int n_beats = 0;
   int n_errs  = 0;
   string scen = "R1";

   always #4 clk = ~clk;

   mem_pattern_seq u_mem_pattern_seq (
      .clk (clk), .rst_n (rst_n), .ram_we (ram_we), .ram_waddr (ram_waddr),
      .ram_wdata (ram_wdata), .burst_inhibit (burst_inhibit), .req_valid (req_valid),
      .req_ready (req_ready), .req_kind (req_kind), .req_addr (req_addr),
      .req_len (req_len), .req_bank (req_bank), .busy (busy), .ctrl_out (ctrl_out),
      .ta (ta), .beat_start (beat_start), .run_addr (run_addr), .done (done),
      .ack_err (ack_err)
   );

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [WORD_W-1:0] mram [DEPTH];
   int q_entry[$];
   int q_addr[$];
   int q_exp[$];
   bit m_busy  = 0;
   bit m_first = 0;
   int m_pc    = 0;
   int m_acks  = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mram[i] = '0;
         q_entry.delete(); q_addr.delete(); q_exp.delete();
         m_busy = 0; m_first = 0; m_pc = 0; m_acks = 0;
      end else if (!m_busy) begin
         if (ram_we) mram[ram_waddr] = ram_wdata;
         if (req_valid) begin
            bit rw, brst;
            int n, ent, stp;
            rw   = (req_kind < 2);
            brst = rw && (req_addr % 8 == 0) && (req_len % 8 == 0) && (req_len != 0)
                   && !burst_inhibit[req_bank];
            case (req_kind)
               2'd0: ent = brst ? 'h08 : 'h00;
               2'd1: ent = brst ? 'h20 : 'h18;
               2'd2: ent = 'h30;
               default: ent = 'h3C;
            endcase
            n   = brst ? req_len / 8 : (rw ? ((req_len == 0) ? 1 : int'(req_len)) : 1);
            stp = brst ? 8 : 1;
            for (int i = 0; i < n; i++) begin
               q_entry.push_back(ent);
               q_addr.push_back((int'(req_addr) + i * stp) % 65536);
               q_exp.push_back(rw ? (brst ? 8 : 1) : -1);
            end
            m_busy = 1; m_pc = ent; m_first = 1; m_acks = 0;
         end
      end else begin
         logic [WORD_W-1:0] w;
         w = mram[m_pc];
         if (w[CTRL_W+1]) begin
            void'(q_entry.pop_front()); void'(q_addr.pop_front()); void'(q_exp.pop_front());
            if (q_entry.size() == 0) m_busy = 0;
            else begin m_pc = q_entry[0]; m_first = 1; m_acks = 0; end
         end else begin
            m_pc = (m_pc + 1) % DEPTH; m_first = 0; m_acks += int'(w[CTRL_W]);
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         int e_ctrl, e_ta, e_bs, e_done, e_err, e_addr;
         e_ctrl = 0; e_ta = 0; e_bs = 0; e_done = 0; e_err = 0; e_addr = 0;
         if (m_busy) begin
            logic [WORD_W-1:0] w;
            w      = mram[m_pc];
            e_ctrl = int'(w[CTRL_W-1:0]);
            e_ta   = int'(w[CTRL_W]);
            e_bs   = int'(m_first);
            e_done = int'(w[CTRL_W+1] && q_entry.size() == 1);
            e_err  = int'(w[CTRL_W+1] && q_exp[0] >= 0 && (m_acks + int'(w[CTRL_W])) != q_exp[0]);
            e_addr = q_addr[0];
         end
         chk("R4 busy", int'(busy), int'(m_busy));
         chk("R11 req_ready", int'(req_ready), int'(!m_busy));
         chk("R2 ctrl_out", int'(ctrl_out), e_ctrl);
         chk("R2 ta", int'(ta), e_ta);
         chk("R7 beat_start", int'(beat_start), e_bs);
         chk("R5 done", int'(done), e_done);
         chk("R9 ack_err", int'(ack_err), e_err);
         chk("R6 run_addr", int'(run_addr), e_addr);
         if (beat_start) n_beats++;
         if (ack_err) n_errs++;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000) begin
         n_fail++;
         $display("FAIL R4 watchdog expired actual=%0d expected<=60000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   function automatic logic [9:0] pw(bit last, bit ack, logic [7:0] c);
      return {last, ack, c};
   endfunction

   task automatic wr(int a, logic [9:0] d);
      @(negedge clk);
      ram_we = 1'b1; ram_waddr = 6'(a); ram_wdata = d;
      @(negedge clk);
      ram_we = 1'b0;
   endtask

   task automatic run_req(string tag, int kind, int addr, int len, int bank,
                          int exp_runs, int exp_errs);
      scen = tag;
      @(negedge clk);
      n_beats = 0; n_errs = 0;
      req_valid = 1'b1; req_kind = 2'(kind); req_addr = 16'(addr);
      req_len = 8'(len); req_bank = 2'(bank);
      @(negedge clk);
      req_valid = 1'b0;
      while (busy) @(negedge clk);
      chk({tag, " run count"}, n_beats, exp_runs);
      chk({tag, " error count"}, n_errs, exp_errs);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet during reset
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 ctrl_out in reset", int'(ctrl_out), 0);
      chk("R1 ta in reset", int'(ta), 0);
      chk("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;

      // load routines (R2/R3 layout and entry points)
      wr('h00, pw(0, 0, 8'h11)); wr('h01, pw(0, 1, 8'h12)); wr('h02, pw(1, 0, 8'h13));
      wr('h08, pw(0, 0, 8'h21));
      for (int i = 1; i <= 8; i++) wr('h08 + i, pw(i == 8, 1, 8'(8'h21 + i)));
      wr('h18, pw(0, 1, 8'h31)); wr('h19, pw(1, 0, 8'h32));
      for (int i = 0; i < 8; i++) wr('h20 + i, pw(i == 7, 1, 8'(8'h40 + i)));
      for (int i = 0; i < 4; i++) wr('h30 + i, pw(i == 3, 0, 8'(8'h50 + i)));
      wr('h3C, pw(1, 1, 8'h60));

      run_req("R3 read single",       0, 'h100, 1, 0, 1, 0);
      run_req("R6 read one burst",    0, 'h040, 8, 0, 1, 0);
      run_req("R6 read two bursts",   0, 'h080, 16, 3, 2, 0);
      run_req("R7 misaligned read",   0, 'h044, 8, 0, 8, 0);
      run_req("R7 odd length read",   0, 'h200, 5, 1, 5, 0);
      run_req("R7 zero length read",  0, 'h300, 0, 0, 1, 0);
      run_req("R7 wrapping addresses",1, 'hFFFE, 3, 0, 3, 0);
      burst_inhibit = 4'b0100;
      run_req("R8 inhibited bank",    1, 'h040, 8, 2, 8, 0);
      run_req("R3 write burst",       1, 'h048, 8, 1, 1, 0);
      burst_inhibit = 4'b0000;
      run_req("R12 refresh",          2, 'h123, 0, 0, 1, 0);
      run_req("R9 exception no err",  3, 'h456, 9, 0, 1, 0);

      // R10/R11: write and request while a refresh is running
      scen = "R10 write while busy";
      @(negedge clk);
      n_beats = 0;
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 16'h0; req_len = 8'd0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      ram_we = 1'b1; ram_waddr = 6'h00; ram_wdata = pw(1, 1, 8'hEE);
      req_valid = 1'b1; req_kind = 2'd0; req_len = 8'd1;
      @(negedge clk);
      ram_we = 1'b0; req_valid = 1'b0;
      while (busy) @(negedge clk);
      chk("R11 busy request ignored", n_beats, 1);
      run_req("R10 store unchanged",  0, 'h010, 1, 0, 1, 0);

      // R9: wrong acknowledge counts
      wr('h19, pw(1, 1, 8'h32));
      run_req("R9 single two acks",   1, 'h020, 1, 0, 1, 1);
      wr('h10, pw(1, 0, 8'h29));
      run_req("R9 burst seven acks",  0, 'h080, 16, 0, 2, 2);

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule